// File: doc/BRIEF.md
# Data Access Alignment Trap Unit

This block sits beside the load/store pipeline of a processor core and checks every data access for natural alignment. Two address-generator lanes can each present one access per cycle, with an address, a size code, a load/store flag, a valid bit and the program counter of the instruction that issued it. Byte accesses are always accepted. Halfword accesses must sit on an even address. Word accesses must sit on an address that is a multiple of four.

When a lane presents a misaligned access, the whole instruction is cancelled. No write enable and no register-update enable leaves the block for either lane in that cycle. On the next clock edge the unit raises a one-cycle trap request. In the same edge it records three things: a cause word, the address exactly as it was issued, and the PC of the faulting instruction. A return from the handler therefore re-executes the same access once software has repaired the pointer.

Lane 0 has priority when both lanes fault together. Software can preset the fault address register. Accesses are accepted in every cycle with no back-pressure: the lanes carry a valid qualifier only and have no ready, because the check is combinational and never stalls.

Top module: `atu_trap_unit`

## Requirements
- R1: A halfword access (size code 01) with address bit 0 set traps. A halfword access with bit 0 clear does not.
- R2: A word access (size code 10, and code 11, which is checked the same way) traps when address bits [1:0] are 01, 10 or 11. It does not trap when they are 00.
- R3: A byte access (size code 00) never traps, whatever its address.
- R4: Loads (store flag 0) and stores (store flag 1) are checked by identical rules and produce identical trap results.
- R5: Lane 1 is checked by the same rules as lane 0, and its faults are recorded in the same way.
- R6: After a trap, the cause output reads 0x24. In that value, bit 5 is the privileged-mode flag and the low bits hold alignment code 0x04.
- R7: After a trap, the fault address output holds the full unaligned address as it was issued.
- R8: After a trap, the return PC output holds the PC of the faulting instruction itself.
- R9: In a cycle where any valid lane is misaligned, all write enables and read enables of both lanes are low. A valid aligned access raises its lane's write enable (store) or read enable (load) in the same cycle.
- R10: When both lanes are misaligned in the same cycle, the lane 0 address and PC are recorded, and exactly one trap pulse is raised.
- R11: The trap request is high for exactly the one cycle after a faulting access. It stays low after cycles with no fault.
- R12: A software write updates the fault address register on the next edge. When a fault happens in the same cycle, the fault address wins.
- R13: A synchronous reset clears the cause, fault address, return PC and trap request to zero. Without a fault, the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a0_valid | input | 1 | Lane 0 access present |
| a0_addr | input | AW | Lane 0 byte address |
| a0_size | input | 2 | Lane 0 size: 00 byte, 01 halfword, 10/11 word |
| a0_store | input | 1 | Lane 0: 1 store, 0 load |
| a0_pc | input | PW | Lane 0 issuing instruction PC |
| a1_valid | input | 1 | Lane 1 access present |
| a1_addr | input | AW | Lane 1 byte address |
| a1_size | input | 2 | Lane 1 size code |
| a1_store | input | 1 | Lane 1 store flag |
| a1_pc | input | PW | Lane 1 issuing instruction PC |
| fa_wr | input | 1 | Software write strobe for the fault address register |
| fa_wdata | input | AW | Software write data for the fault address register |
| a0_wr_en | output | 1 | Lane 0 memory write allowed |
| a0_rd_en | output | 1 | Lane 0 load result update allowed |
| a1_wr_en | output | 1 | Lane 1 memory write allowed |
| a1_rd_en | output | 1 | Lane 1 load result update allowed |
| trap_req | output | 1 | One-cycle exception request |
| cause | output | 8 | Recorded exception cause |
| fault_addr | output | AW | Recorded faulting address |
| ret_pc | output | PW | Recorded return PC |

## Verification
The assertions check the following on every cycle:
- no enable is raised while either lane is misaligned;
- each fault is followed by a pulse with cause 0x24;
- the recorded address and PC match the lane 0 values when lane 0 faulted, and the lane 1 values otherwise;
- the registers hold still when there is no fault and no write;
- reset clears everything.

Only the bench scenarios can show the following:
- the full matrix of size, offset, lane and direction gives the right yes/no trap decision;
- a software write loses to a fault in the same cycle;
- the values in the registers persist across a series of aligned accesses.

// File: rtl/atu_pkg.sv
package atu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  localparam logic       PRIV_FLAG      = 1'b1;
  localparam logic [4:0] ALIGN_CODE     = 5'h04;
  localparam logic [7:0] CAUSE_MISALIGN = {2'b00, PRIV_FLAG, ALIGN_CODE};
endpackage

// File: rtl/atu_align_chk.sv
module atu_align_chk #(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          misal
);
  import atu_pkg::*;

  acc_size_e sz;
  logic      off_bad;

  always_comb begin
    sz = acc_size_e'(size);
    unique case (sz)
      SZ_BYTE:          off_bad = 1'b0;
      SZ_HALF:          off_bad = addr[0];
      SZ_WORD, SZ_WIDE: off_bad = addr[1] | addr[0];
      default:          off_bad = 1'b0;
    endcase
    misal = valid & off_bad;
  end
endmodule

// File: rtl/atu_fault_sel.sv
module atu_fault_sel #(
  parameter int AW = 32,
  parameter int PW = 32,
  parameter int NP = 2
) (
  input  logic [NP-1:0]    misal,
  input  logic [NP*AW-1:0] addr_flat,
  input  logic [NP*PW-1:0] pc_flat,
  output logic             any_fault,
  output logic [AW-1:0]    sel_addr,
  output logic [PW-1:0]    sel_pc
);
  // Lowest-numbered faulting lane wins: scan from the top down.
  always_comb begin
    any_fault = |misal;
    sel_addr  = '0;
    sel_pc    = '0;
    for (int i = NP-1; i >= 0; i--) begin
      if (misal[i]) begin
        sel_addr = addr_flat[i*AW +: AW];
        sel_pc   = pc_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/atu_trap_regs.sv
module atu_trap_regs #(
  parameter int AW = 32,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fault,
  input  logic [AW-1:0] f_addr,
  input  logic [PW-1:0] f_pc,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_data,
  output logic          trap_q,
  output logic [7:0]    cause_q,
  output logic [AW-1:0] addr_q,
  output logic [PW-1:0] pc_q
);
  import atu_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q  <= 1'b0;
      cause_q <= '0;
      addr_q  <= '0;
      pc_q    <= '0;
    end else begin
      trap_q <= fault;
      if (fault) begin
        cause_q <= CAUSE_MISALIGN;
        addr_q  <= f_addr;
        pc_q    <= f_pc;
      end else if (sw_wr) begin
        addr_q  <= sw_data;
      end
    end
  end

  // R12: a software write alone lands on the next edge
  p_sw_write_r12: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && !fault) |=> (addr_q == $past(sw_data)));
endmodule

// File: rtl/atu_trap_unit.sv
module atu_trap_unit #(
  parameter int AW = 32,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a0_valid,
  input  logic [AW-1:0] a0_addr,
  input  logic [1:0]    a0_size,
  input  logic          a0_store,
  input  logic [PW-1:0] a0_pc,
  input  logic          a1_valid,
  input  logic [AW-1:0] a1_addr,
  input  logic [1:0]    a1_size,
  input  logic          a1_store,
  input  logic [PW-1:0] a1_pc,
  input  logic          fa_wr,
  input  logic [AW-1:0] fa_wdata,
  output logic          a0_wr_en,
  output logic          a0_rd_en,
  output logic          a1_wr_en,
  output logic          a1_rd_en,
  output logic          trap_req,
  output logic [7:0]    cause,
  output logic [AW-1:0] fault_addr,
  output logic [PW-1:0] ret_pc
);
  import atu_pkg::*;

  localparam int NP = 2;

  logic [NP-1:0]    v_vec, st_vec, misal, wr_vec, rd_vec;
  logic [NP*2-1:0]  sz_flat;
  logic [NP*AW-1:0] addr_flat;
  logic [NP*PW-1:0] pc_flat;
  logic             any_fault;
  logic [AW-1:0]    sel_addr;
  logic [PW-1:0]    sel_pc;

  assign v_vec     = {a1_valid, a0_valid};
  assign st_vec    = {a1_store, a0_store};
  assign sz_flat   = {a1_size, a0_size};
  assign addr_flat = {a1_addr, a0_addr};
  assign pc_flat   = {a1_pc, a0_pc};

  for (genvar g = 0; g < NP; g++) begin : g_lane
    atu_align_chk #(.AW(AW)) u_chk (
      .valid (v_vec[g]),
      .addr  (addr_flat[g*AW +: AW]),
      .size  (sz_flat[g*2 +: 2]),
      .misal (misal[g])
    );
    // A fault on either lane cancels the whole instruction.
    assign wr_vec[g] = v_vec[g] & ~any_fault &  st_vec[g];
    assign rd_vec[g] = v_vec[g] & ~any_fault & ~st_vec[g];
  end

  atu_fault_sel #(.AW(AW), .PW(PW), .NP(NP)) u_sel (
    .misal     (misal),
    .addr_flat (addr_flat),
    .pc_flat   (pc_flat),
    .any_fault (any_fault),
    .sel_addr  (sel_addr),
    .sel_pc    (sel_pc)
  );

  atu_trap_regs #(.AW(AW), .PW(PW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .fault   (any_fault),
    .f_addr  (sel_addr),
    .f_pc    (sel_pc),
    .sw_wr   (fa_wr),
    .sw_data (fa_wdata),
    .trap_q  (trap_req),
    .cause_q (cause),
    .addr_q  (fault_addr),
    .pc_q    (ret_pc)
  );

  assign a0_wr_en = wr_vec[0];
  assign a0_rd_en = rd_vec[0];
  assign a1_wr_en = wr_vec[1];
  assign a1_rd_en = rd_vec[1];

  // Port-level reference classification used by the checks below
  logic m0_ref, m1_ref, any_ref;
  assign m0_ref  = a0_valid && ((a0_size == 2'b01 && a0_addr[0]) ||
                                (a0_size[1] && a0_addr[1:0] != 2'b00));
  assign m1_ref  = a1_valid && ((a1_size == 2'b01 && a1_addr[0]) ||
                                (a1_size[1] && a1_addr[1:0] != 2'b00));
  assign any_ref = m0_ref || m1_ref;

  p_suppress_r9: assert property (@(posedge clk) disable iff (rst)
    any_ref |-> !(a0_wr_en || a0_rd_en || a1_wr_en || a1_rd_en));

  p_cause_r6: assert property (@(posedge clk) disable iff (rst)
    any_ref |=> (trap_req && cause == CAUSE_MISALIGN));

  p_addr_r7: assert property (@(posedge clk) disable iff (rst)
    any_ref |=> (fault_addr == $past(m0_ref ? a0_addr : a1_addr)));

  p_pc_r8: assert property (@(posedge clk) disable iff (rst)
    any_ref |=> (ret_pc == $past(m0_ref ? a0_pc : a1_pc)));

  p_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (a0_valid && a0_size == 2'b00 && !a1_valid) |=> !trap_req);

  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !any_ref |=> !trap_req);

  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!any_ref && !fa_wr) |=> ($stable(fault_addr) && $stable(ret_pc) && $stable(cause)));

  p_reset_r13: assert property (@(posedge clk)
    rst |=> (!trap_req && cause == 8'h00 && fault_addr == '0 && ret_pc == '0));
endmodule

// File: tb/sim_atu_trap_unit.sv
module sim_atu_trap_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int PW = 32;
  localparam int NV = 21;
  localparam int WATCHDOG = 5000;

  // Entry: {lane, store, size[1:0], addr_lo[1:0], expect_trap}
  localparam logic [6:0] VEC [0:NV-1] = '{
    7'b0_1_01_01_1, 7'b0_1_10_01_1, 7'b0_1_10_10_1, 7'b0_1_10_11_1,
    7'b1_1_01_01_1, 7'b1_1_10_01_1, 7'b1_1_10_10_1, 7'b1_1_10_11_1,
    7'b0_0_01_01_1, 7'b0_0_10_01_1, 7'b0_0_10_10_1, 7'b0_0_10_11_1,
    7'b1_0_01_01_1, 7'b1_0_10_01_1, 7'b1_0_10_10_1, 7'b1_0_11_11_1,
    7'b0_0_01_10_0, 7'b1_1_10_00_0, 7'b0_1_00_11_0, 7'b1_0_00_01_0,
    7'b0_1_01_00_0
  };

  logic clk = 1'b0;
  logic rst;
  logic a0_valid, a0_store, a1_valid, a1_store, fa_wr;
  logic [AW-1:0] a0_addr, a1_addr, fa_wdata;
  logic [1:0] a0_size, a1_size;
  logic [PW-1:0] a0_pc, a1_pc;
  logic a0_wr_en, a0_rd_en, a1_wr_en, a1_rd_en, trap_req;
  logic [7:0] cause;
  logic [AW-1:0] fault_addr;
  logic [PW-1:0] ret_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] e_cause = 8'h00;
  logic [AW-1:0] e_fa = '0;
  logic [PW-1:0] e_pc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atu_trap_unit #(.AW(AW), .PW(PW)) u0 (
    .clk(clk), .rst(rst),
    .a0_valid(a0_valid), .a0_addr(a0_addr), .a0_size(a0_size), .a0_store(a0_store), .a0_pc(a0_pc),
    .a1_valid(a1_valid), .a1_addr(a1_addr), .a1_size(a1_size), .a1_store(a1_store), .a1_pc(a1_pc),
    .fa_wr(fa_wr), .fa_wdata(fa_wdata),
    .a0_wr_en(a0_wr_en), .a0_rd_en(a0_rd_en), .a1_wr_en(a1_wr_en), .a1_rd_en(a1_rd_en),
    .trap_req(trap_req), .cause(cause), .fault_addr(fault_addr), .ret_pc(ret_pc)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    a0_valid = 0; a1_valid = 0; fa_wr = 0;
    a0_addr = '0; a1_addr = '0; a0_size = 2'b00; a1_size = 2'b00;
    a0_store = 0; a1_store = 0; a0_pc = '0; a1_pc = '0; fa_wdata = '0;
  endtask

  task automatic check_regs(input string req);
    chk(cause == e_cause, {req, " cause"}, {24'h0, cause}, {24'h0, e_cause});
    chk(fault_addr == e_fa, {req, " fault_addr"}, fault_addr, e_fa);
    chk(ret_pc == e_pc, {req, " ret_pc"}, ret_pc, e_pc);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R13 reset state
    chk(trap_req == 0, "R13 reset trap", {31'h0, trap_req}, 0);
    check_regs("R13 reset");

    // Table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic ln, st, ex;
      logic [1:0] sz, lo;
      logic [AW-1:0] ad;
      logic [PW-1:0] pc;
      {ln, st, sz, lo, ex} = VEC[i];
      ad = 32'h0000_1000 | {30'h0, lo};
      pc = 32'h0000_0200 + 32'(i*4);
      @(negedge clk);
      idle();
      if (ln == 0) begin
        a0_valid = 1; a0_addr = ad; a0_size = sz; a0_store = st; a0_pc = pc;
      end else begin
        a1_valid = 1; a1_addr = ad; a1_size = sz; a1_store = st; a1_pc = pc;
      end
      #1;
      begin
        logic we, re;
        we = ln ? a1_wr_en : a0_wr_en;
        re = ln ? a1_rd_en : a0_rd_en;
        chk(we == (!ex && st), "R9 write enable", {31'h0, we}, {31'h0, !ex && st});
        chk(re == (!ex && !st), "R9 read enable", {31'h0, re}, {31'h0, !ex && !st});
      end
      @(posedge clk); #1;
      if (ex) begin e_cause = 8'h24; e_fa = ad; e_pc = pc; end
      chk(trap_req == ex, "R1/R2/R3/R4/R5 trap decision", {31'h0, trap_req}, {31'h0, ex});
      check_regs("R6 R7 R8 table");
      @(negedge clk); idle();
      @(posedge clk); #1;
      chk(trap_req == 0, "R11 single pulse", {31'h0, trap_req}, 0);
    end

    // R12 software write
    @(negedge clk); idle(); fa_wr = 1; fa_wdata = 32'h0000_0055;
    @(posedge clk); #1; e_fa = 32'h55;
    check_regs("R12 sw write");
    // R12 collision: fault wins
    @(negedge clk); idle(); fa_wr = 1; fa_wdata = 32'h0000_0077;
    a0_valid = 1; a0_addr = 32'h2003; a0_size = 2'b10; a0_pc = 32'h0000_0700;
    @(posedge clk); #1; e_fa = 32'h2003; e_pc = 32'h700;
    check_regs("R12 collision");

    // R10 both lanes misaligned
    @(negedge clk); idle();
    a0_valid = 1; a0_addr = 32'h3001; a0_size = 2'b01; a0_pc = 32'h900;
    a1_valid = 1; a1_addr = 32'h4002; a1_size = 2'b10; a1_pc = 32'h904; a1_store = 1;
    @(posedge clk); #1; e_fa = 32'h3001; e_pc = 32'h900;
    chk(trap_req == 1, "R10 trap", {31'h0, trap_req}, 1);
    check_regs("R10 lane0 priority");
    @(negedge clk); idle();
    @(posedge clk); #1;
    chk(trap_req == 0, "R10 one pulse", {31'h0, trap_req}, 0);

    // R9 aligned lane 0 cancelled by misaligned lane 1
    @(negedge clk); idle();
    a0_valid = 1; a0_addr = 32'h5000; a0_size = 2'b10; a0_store = 1; a0_pc = 32'hA00;
    a1_valid = 1; a1_addr = 32'h6001; a1_size = 2'b01; a1_pc = 32'hA00;
    #1;
    chk(a0_wr_en == 0, "R9 cross-lane cancel", {31'h0, a0_wr_en}, 0);
    @(posedge clk); #1; e_fa = 32'h6001; e_pc = 32'hA00;
    check_regs("R5 lane1 record");

    // R13 hold over idle cycles, then reset clears
    @(negedge clk); idle();
    repeat (3) @(posedge clk); #1;
    check_regs("R13 hold");
    @(negedge clk); rst = 1;
    @(posedge clk); #1; rst = 0;
    e_cause = 0; e_fa = 0; e_pc = 0;
    check_regs("R13 reset clear");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule